// File: doc/BRIEF.md
# Power State Sequencing Controller

This controller decides whether the chip sits in a low-power standby state or in its full operating state. It gates the CPU clock and the PLL, holds the external address and data buses low while the chip is asleep, and records why the chip was last reset. Software asks for standby with a request strobe. The request takes effect only when no interrupt is waiting.

The always-on clock domain is modelled as a single enable, `tick`. The state machine and the wake synchronizer advance only on cycles where `tick` is high. The resets and the status flags act on every clock.

Wake-up depends on how standby was entered. After a power-on reset, only a rising edge on the external wake pin can start the chip. After standby is entered through software or through a user or power-fail reset, a keyboard line going high can also wake the chip, provided keyboard wake is enabled.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `por_n` is low, the block is asynchronously held in standby (`op_state`=0) with `cold_flag`=1, `pfail_flag`=0 and `rtc_valid`=0.
- R2: `op_state`=1 means operating and 0 means standby; the only move out of standby is to operating. `cpu_clk_en` and `pll_en` are high exactly when operating. `bus_hold_low` is high exactly when in standby.
- R3: In standby entered by power-on reset, only a low-to-high change of `wake_pin` wakes the block. The pin passes through a two-stage synchronizer, and the edge is detected against the previous synchronized sample. With `tick` high, `op_state` rises at the third rising clock edge after the pin goes high. Keyboard lines are ignored in this standby.
- R4: In standby entered any other way, a tick with `kbd_wake_en`=1 and any `kbd_in` bit high wakes the block at that edge. With `kbd_wake_en`=0, the keyboard lines have no effect.
- R5: While operating, `sby_req` is ignored on any tick where `irq_pending` is high.
- R6: While operating, `sby_req` with `irq_pending` low on a tick enters standby at that edge.
- R7: A low `usr_rst_n` or `pfail_rst_n` puts the block in standby at the next clock edge, whatever the value of `tick`. A low `pfail_rst_n` sets `pfail_flag`. A standby entered this way is not a cold standby.
- R8: `flag_clr` clears both flags at the next edge. A power-fail reset in the same cycle still sets `pfail_flag`.
- R9: `rtc_valid` is set on the first entry to operating. Only power-on reset clears it; user and power-fail resets leave it set.
- R10: With `tick` low, the state does not change except through the resets, and the wake synchronizer takes no new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| usr_rst_n | input | 1 | User reset, active low, synchronous |
| pfail_rst_n | input | 1 | Power-fail reset, active low, synchronous |
| tick | input | 1 | Always-on domain enable |
| wake_pin | input | 1 | External wake pin, active high, asynchronous |
| kbd_wake_en | input | 1 | Allows keyboard lines to wake the block |
| kbd_in | input | KBD_W | Keyboard port lines |
| irq_pending | input | 1 | Any interrupt request is pending |
| sby_req | input | 1 | Software standby request |
| flag_clr | input | 1 | Clears the status flags |
| op_state | output | 1 | 1 operating, 0 standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| pll_en | output | 1 | PLL enable |
| bus_hold_low | output | 1 | Forces the external buses low |
| cold_flag | output | 1 | Power-on reset seen |
| pfail_flag | output | 1 | Power-fail reset seen |
| rtc_valid | output | 1 | RTC contents preserved |

## Verification
The assertions check the cycle-local rules on every clock. These are: a user or power-fail reset lands the block in standby, a pending interrupt keeps it operating, nothing moves without a tick, the flags set and clear as required, and `rtc_valid` never drops without a power-on reset.

Only the bench scenarios can show the rules that depend on history:
- the three-edge wake latency through the synchronizer;
- that keyboard lines are ignored after a cold reset but wake the block after a warm entry;
- the ordering of a flag clear against a simultaneous power-fail reset.

The bench checks these against a behavioural model on every cycle.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int KBD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             usr_rst_n,
  input  logic             pfail_rst_n,
  input  logic             tick,
  input  logic             wake_pin,
  input  logic             kbd_wake_en,
  input  logic [KBD_W-1:0] kbd_in,
  input  logic             irq_pending,
  input  logic             sby_req,
  input  logic             flag_clr,
  output logic             op_state,
  output logic             cpu_clk_en,
  output logic             pll_en,
  output logic             bus_hold_low,
  output logic             cold_flag,
  output logic             pfail_flag,
  output logic             rtc_valid
);

  typedef enum logic {ST_STBY = 1'b0, ST_RUN = 1'b1} pstate_t;

  pstate_t              st;
  logic                 cold_mode;
  logic [SYNC_STAGES:0] wsh;

  logic warm_rst, wake_rise, kbd_hit, go_run, go_stby;

  assign warm_rst  = ~usr_rst_n | ~pfail_rst_n;
  assign wake_rise = wsh[SYNC_STAGES-1] & ~wsh[SYNC_STAGES];
  assign kbd_hit   = kbd_wake_en & (|kbd_in) & ~cold_mode;
  assign go_run    = tick & (st == ST_STBY) & (wake_rise | kbd_hit);
  assign go_stby   = tick & (st == ST_RUN) & sby_req & ~irq_pending;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st         <= ST_STBY;
      cold_mode  <= 1'b1;
      cold_flag  <= 1'b1;
      pfail_flag <= 1'b0;
      rtc_valid  <= 1'b0;
      wsh        <= '0;
    end else begin
      if (tick) wsh <= {wsh[SYNC_STAGES-1:0], wake_pin};
      if (flag_clr) begin
        cold_flag  <= 1'b0;
        pfail_flag <= 1'b0;
      end
      if (!pfail_rst_n) pfail_flag <= 1'b1;
      if (warm_rst) begin
        st        <= ST_STBY;
        cold_mode <= 1'b0;
      end else if (go_run) begin
        st        <= ST_RUN;
        cold_mode <= 1'b0;
        rtc_valid <= 1'b1;
      end else if (go_stby) begin
        st <= ST_STBY;
      end
    end
  end

  assign op_state     = (st == ST_RUN);
  assign cpu_clk_en   = op_state;
  assign pll_en       = op_state;
  assign bus_hold_low = ~op_state;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic por_n,
  input logic usr_rst_n,
  input logic pfail_rst_n,
  input logic tick,
  input logic irq_pending,
  input logic flag_clr,
  input logic op_state,
  input logic cold_flag,
  input logic pfail_flag,
  input logic rtc_valid
);

  AST_RESET_TO_STBY: assert property (@(posedge clk) disable iff (!por_n)
    (!usr_rst_n || !pfail_rst_n) |=> !op_state); // R7

  AST_PFAIL_SETS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    !pfail_rst_n |=> pfail_flag); // R7

  AST_IRQ_BLOCKS_SBY: assert property (@(posedge clk) disable iff (!por_n)
    (op_state && irq_pending && usr_rst_n && pfail_rst_n) |=> op_state); // R5

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    (!tick && usr_rst_n && pfail_rst_n) |=> $stable(op_state)); // R10

  AST_RUN_NEEDS_TICK: assert property (@(posedge clk) disable iff (!por_n)
    $rose(op_state) |-> $past(tick)); // R2

  AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!por_n)
    (flag_clr && pfail_rst_n) |=> (!cold_flag && !pfail_flag)); // R8

  AST_RTC_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    rtc_valid |=> rtc_valid); // R9

endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk(clk), .por_n(por_n), .usr_rst_n(usr_rst_n), .pfail_rst_n(pfail_rst_n),
  .tick(tick), .irq_pending(irq_pending), .flag_clr(flag_clr),
  .op_state(op_state), .cold_flag(cold_flag), .pfail_flag(pfail_flag),
  .rtc_valid(rtc_valid)
);

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0, usr_rst_n = 1'b1, pfail_rst_n = 1'b1, tick = 1'b1;
  logic wake_pin = 1'b0, kbd_wake_en = 1'b0, irq_pending = 1'b0, sby_req = 1'b0, flag_clr = 1'b0;
  logic [KW-1:0] kbd_in = '0;
  logic op_state, cpu_clk_en, pll_en, bus_hold_low, cold_flag, pfail_flag, rtc_valid;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  pwr_seq_ctrl #(.KBD_W(KW)) dut (
    .clk(clk), .por_n(por_n), .usr_rst_n(usr_rst_n), .pfail_rst_n(pfail_rst_n),
    .tick(tick), .wake_pin(wake_pin), .kbd_wake_en(kbd_wake_en), .kbd_in(kbd_in),
    .irq_pending(irq_pending), .sby_req(sby_req), .flag_clr(flag_clr),
    .op_state(op_state), .cpu_clk_en(cpu_clk_en), .pll_en(pll_en),
    .bus_hold_low(bus_hold_low), .cold_flag(cold_flag), .pfail_flag(pfail_flag),
    .rtc_valid(rtc_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_ok = 0;
  bit m_op, m_cold, m_cf, m_pf, m_rtc;
  int hist[$];

  always @(posedge clk) begin
    if (!por_n) begin
      m_op = 0; m_cold = 1; m_cf = 1; m_pf = 0; m_rtc = 0;
      hist = {0, 0, 0};
      m_ok = 1;
    end else if (m_ok) begin
      if (flag_clr) begin m_cf = 0; m_pf = 0; end
      if (!pfail_rst_n) m_pf = 1;
      if (!usr_rst_n || !pfail_rst_n) begin
        m_op = 0; m_cold = 0;
      end else if (tick) begin
        if (!m_op) begin
          if ((hist[1] == 1 && hist[2] == 0) || (!m_cold && kbd_wake_en && kbd_in != 0)) begin
            m_op = 1; m_cold = 0; m_rtc = 1;
          end
        end else if (sby_req && !irq_pending) begin
          m_op = 0;
        end
      end
      if (tick) begin
        hist.push_front(int'(wake_pin));
        void'(hist.pop_back());
      end
    end
    if (m_ok) begin
      #(CLK_PERIOD/4);
      chk("R2", "op_state", op_state, m_op);
      chk("R2", "cpu_clk_en", cpu_clk_en, m_op);
      chk("R2", "pll_en", pll_en, m_op);
      chk("R2", "bus_hold_low", bus_hold_low, !m_op);
      chk("R1", "cold_flag", cold_flag, m_cf);
      chk("R7", "pfail_flag", pfail_flag, m_pf);
      chk("R9", "rtc_valid", rtc_valid, m_rtc);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R1", "reset op_state", op_state, 1'b0);
    chk("R1", "reset cold_flag", cold_flag, 1'b1);
    chk("R1", "reset pfail_flag", pfail_flag, 1'b0);
    chk("R1", "reset rtc_valid", rtc_valid, 1'b0);
    chk("R2", "reset bus_hold_low", bus_hold_low, 1'b1);
    por_n = 1;
    // R3: keyboard ignored in cold standby
    kbd_wake_en = 1; kbd_in = 8'h01;
    step(8);
    chk("R3", "kbd ignored after por", op_state, 1'b0);
    kbd_in = '0; kbd_wake_en = 0;
    // R3: wake latency
    wake_pin = 1;
    step(2);
    chk("R3", "not yet awake", op_state, 1'b0);
    step(1);
    chk("R3", "awake at third edge", op_state, 1'b1);
    chk("R9", "rtc set on wake", rtc_valid, 1'b1);
    wake_pin = 0;
    step(2);
    // R8
    flag_clr = 1; step(1); flag_clr = 0;
    chk("R8", "cold_flag cleared", cold_flag, 1'b0);
    // R5
    irq_pending = 1; sby_req = 1;
    step(4);
    chk("R5", "sby ignored with irq", op_state, 1'b1);
    irq_pending = 0;
    step(1);
    chk("R6", "sby taken", op_state, 1'b0);
    sby_req = 0;
    // R4
    kbd_in = 8'h04;
    step(5);
    chk("R4", "kbd without enable", op_state, 1'b0);
    kbd_wake_en = 1;
    step(1);
    chk("R4", "kbd wake", op_state, 1'b1);
    kbd_in = '0; kbd_wake_en = 0;
    // R10
    sby_req = 1; tick = 0;
    step(4);
    chk("R10", "no tick holds run", op_state, 1'b1);
    tick = 1; step(1);
    chk("R10", "tick lets sby through", op_state, 1'b0);
    sby_req = 0; tick = 0; wake_pin = 1;
    step(6);
    chk("R10", "no tick no wake", op_state, 1'b0);
    tick = 1;
    step(2);
    chk("R10", "sync resumes", op_state, 1'b0);
    step(1);
    chk("R10", "wake after resumed ticks", op_state, 1'b1);
    wake_pin = 0;
    step(2);
    // R7 with tick low
    tick = 0; pfail_rst_n = 0; step(1); pfail_rst_n = 1; tick = 1;
    chk("R7", "pfail to standby", op_state, 1'b0);
    chk("R7", "pfail flag", pfail_flag, 1'b1);
    chk("R9", "rtc kept over pfail", rtc_valid, 1'b1);
    kbd_wake_en = 1; kbd_in = 8'h80; step(1);
    chk("R7", "warm standby kbd wake", op_state, 1'b1);
    kbd_in = '0; kbd_wake_en = 0;
    // user reset + clear
    usr_rst_n = 0; flag_clr = 1; step(1); usr_rst_n = 1;
    chk("R7", "user reset standby", op_state, 1'b0);
    chk("R8", "clear with user reset", pfail_flag, 1'b0);
    pfail_rst_n = 0; step(1); pfail_rst_n = 1; flag_clr = 0;
    chk("R8", "pfail set beats clear", pfail_flag, 1'b1);
    chk("R9", "rtc kept over user reset", rtc_valid, 1'b1);
    step(2);
    // por again
    por_n = 0; #1;
    chk("R9", "por clears rtc", rtc_valid, 1'b0);
    chk("R1", "por sets cold", cold_flag, 1'b1);
    chk("R1", "por clears pfail", pfail_flag, 1'b0);
    step(2); por_n = 1;
    step(5);
    done = 1;
  end

  initial begin
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    #(CLK_PERIOD);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule